// File: doc/BRIEF.md
# Software Standby Power Controller

This block decides when a small microcontroller system drops into a software standby state and how it climbs back out. When the processor signals a sleep instruction, the block checks three configuration bits. If they allow standby, it gates the processor and peripheral clocks off and turns the clock generator off. It also sends a one-cycle reinitialisation strobe to the peripherals that lose their state in standby: the serial unit and the two PWM units. Register and memory contents are kept by the rest of the chip, because the clocks simply stop.

The block leaves standby in one of three ways:
- **Wake interrupt.** An edge on NMI, in the configured direction, or a qualified request on one of the wake-capable IRQ lines turns the oscillator back on. The block then counts a settling interval picked by a 3-bit field. When the count ends, it restores the clocks and raises a one-cycle wake-interrupt request.
- **Reset pin.** Pulling the reset pin low restores the oscillator and all clocks at once. A reset-start strobe is issued when the pin returns high.
- **Hardware-standby pin.** Pulling this pin low overrides everything else and moves the block into hardware standby.

The controller itself runs on an always-on clock.

Top module: `stby_ctrl`

## Requirements
- R1: A sleep strobe in the run state enters standby only when standby-enable is 1, low-speed-select is 0 and watchdog-source-select is 0.
- R2: In standby, `osc_en`, `cpu_clk_en` and `per_clk_en` are all 0 from the clock edge that samples the accepted sleep strobe. In the run state all three are 1.
- R3: `per_reinit` is high for exactly the one cycle in which standby is first entered.
- R4: Only IRQ lines 0, 1, 2, 6 and 7 (bit i of `irq_req` is line i) can wake the block from standby. A request on lines 3, 4 or 5 leaves it in standby.
- R5: An IRQ wakes the block only when its `irq_en` bit is 1 and `irq_mask` is 0.
- R6: On a wake, `osc_en` is 1 from the next edge onward. Clocks stay off for exactly 2^(BASE_LOG2+sel) cycles, where sel is the `cfg_settle_sel` value. Then `cpu_clk_en` and `per_clk_en` return to 1 together with a one-cycle `wake_req`, and `wake_nmi` is 1 when the source was NMI.
- R7: The reset pin `res_n` low during standby turns on the oscillator and all clocks at the next edge. A one-cycle `reset_go` pulse follows the edge that samples `res_n` high again.
- R8: `hwstby_n` low moves the block to hardware standby (`hw_stby` = 1, clocks and oscillator off) at the next edge. When the pin is released, the block passes through reset hold.
- R9: `cfg_nmi_rise` = 0 wakes on a falling NMI edge and `cfg_nmi_rise` = 1 wakes on a rising edge. The opposite edge does not wake the block.
- R10: When several wake and exit causes arrive in the same cycle, they are served in this order: hardware-standby pin, then reset pin, then NMI, then IRQ.
- R11: A sleep strobe that does not meet R1 leaves the block in the run state with all clocks on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | always-on controller clock |
| rst_n | input | 1 | power-on reset of the controller, active low |
| sleep_req | input | 1 | sleep-instruction strobe |
| cfg_stby_en | input | 1 | standby enable |
| cfg_lowspd | input | 1 | low-speed select (blocks standby) |
| cfg_wdt_src | input | 1 | watchdog clock-source select (blocks standby) |
| cfg_settle_sel | input | 3 | settling-time select |
| cfg_nmi_rise | input | 1 | NMI edge select, 1 = rising |
| irq_req | input | 8 | IRQ request levels, bit i = line i |
| irq_en | input | 8 | per-line IRQ enable |
| irq_mask | input | 1 | CPU-side interrupt mask |
| nmi_pin | input | 1 | NMI pin level |
| res_n | input | 1 | reset pin, active low |
| hwstby_n | input | 1 | hardware-standby pin, active low |
| osc_en | output | 1 | clock generator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | peripheral clock gate enable |
| per_reinit | output | 1 | reinitialise non-retained peripherals |
| wake_req | output | 1 | wake interrupt request pulse |
| wake_nmi | output | 1 | wake source was NMI (with wake_req) |
| reset_go | output | 1 | begin reset handling pulse |
| hw_stby | output | 1 | hardware-standby indication |

## Verification
Entry is tried with every combination of the three gating bits. This separates a correct AND of all three from a check that drops one of them. In standby, random mixes of IRQ request, enable and mask bits are applied. They show whether the wake-line subset, the enable and the mask are each honoured, and whether settling lengths for all eight select codes give the exact cycle count. Directed cases fire NMI with the wrong edge and then the right edge, and fire the reset and hardware-standby pins in the same cycle as an NMI edge. These cases tell apart the edge selection and each step of the priority order.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_STBY    = 3'd1,
        ST_SETTLE  = 3'd2,
        ST_RSTHOLD = 3'd3,
        ST_HWSTBY  = 3'd4
    } pm_state_e;

    typedef struct packed {
        pm_state_e st;
        logic      reinit;
        logic      wake;
        logic      wake_nmi;
        logic      rst_go;
    } fsm_regs_t;

endpackage

// File: rtl/stby_wake_detect.sv
module stby_wake_detect #(
    parameter int                 NUM_IRQ    = 8,
    parameter logic [NUM_IRQ-1:0] WAKE_LINES = 8'hC7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_pin,
    input  logic               nmi_rise_sel,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               irq_mask,
    output logic               nmi_edge,
    output logic               irq_wake
);

    logic               nmi_d, nmi_q;
    logic [NUM_IRQ-1:0] qual;

    always_comb begin
        nmi_d    = nmi_pin;
        nmi_edge = nmi_rise_sel ? (nmi_pin & ~nmi_q) : (~nmi_pin & nmi_q);
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        if (WAKE_LINES[i]) begin : g_wake
            assign qual[i] = irq_req[i] & irq_en[i];
        end else begin : g_ignore
            assign qual[i] = 1'b0;
        end
    end

    assign irq_wake = (|qual) & ~irq_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= nmi_d;
    end

endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer #(
    parameter int BASE_LOG2 = 13,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);

    localparam int CNT_W = BASE_LOG2 + (1 << SEL_W);

    logic [CNT_W-1:0] cnt_d, cnt_q, last_v;

    always_comb begin
        last_v = (CNT_W'(1) << (BASE_LOG2 + int'(sel))) - CNT_W'(1);
        if (start)   cnt_d = '0;
        else if (en) cnt_d = cnt_q + CNT_W'(1);
        else         cnt_d = cnt_q;
        done = en && (cnt_q == last_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int BASE_LOG2 = 13,
    parameter int SEL_W     = 3,
    parameter int NUM_IRQ   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               cfg_stby_en,
    input  logic               cfg_lowspd,
    input  logic               cfg_wdt_src,
    input  logic [SEL_W-1:0]   cfg_settle_sel,
    input  logic               cfg_nmi_rise,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               irq_mask,
    input  logic               nmi_pin,
    input  logic               res_n,
    input  logic               hwstby_n,
    output logic               osc_en,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               per_reinit,
    output logic               wake_req,
    output logic               wake_nmi,
    output logic               reset_go,
    output logic               hw_stby
);

    fsm_regs_t r_d, r_q;
    pm_state_e st_q;
    logic      nmi_edge, irq_wake, settle_start, settle_en, settle_done;
    logic      entry_ok;

    stby_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .clk          (clk),
        .rst_n        (rst_n),
        .nmi_pin      (nmi_pin),
        .nmi_rise_sel (cfg_nmi_rise),
        .irq_req      (irq_req),
        .irq_en       (irq_en),
        .irq_mask     (irq_mask),
        .nmi_edge     (nmi_edge),
        .irq_wake     (irq_wake)
    );

    stby_settle_timer #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (settle_start),
        .en    (settle_en),
        .sel   (cfg_settle_sel),
        .done  (settle_done)
    );

    assign st_q      = r_q.st;
    assign settle_en = (r_q.st == ST_SETTLE);
    assign entry_ok  = sleep_req & cfg_stby_en & ~cfg_lowspd & ~cfg_wdt_src;

    always_comb begin
        r_d          = r_q;
        r_d.reinit   = 1'b0;
        r_d.wake     = 1'b0;
        r_d.rst_go   = 1'b0;
        settle_start = 1'b0;
        unique case (r_q.st)
            ST_RUN: begin
                if (!hwstby_n)   r_d.st = ST_HWSTBY;
                else if (!res_n) r_d.st = ST_RSTHOLD;
                else if (entry_ok) begin
                    r_d.st     = ST_STBY;
                    r_d.reinit = 1'b1;
                end
            end
            ST_STBY: begin
                if (!hwstby_n)   r_d.st = ST_HWSTBY;
                else if (!res_n) r_d.st = ST_RSTHOLD;
                else if (nmi_edge) begin
                    r_d.st       = ST_SETTLE;
                    r_d.wake_nmi = 1'b1;
                    settle_start = 1'b1;
                end else if (irq_wake) begin
                    r_d.st       = ST_SETTLE;
                    r_d.wake_nmi = 1'b0;
                    settle_start = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (!hwstby_n)   r_d.st = ST_HWSTBY;
                else if (!res_n) r_d.st = ST_RSTHOLD;
                else if (settle_done) begin
                    r_d.st   = ST_RUN;
                    r_d.wake = 1'b1;
                end
            end
            ST_RSTHOLD: begin
                if (!hwstby_n) r_d.st = ST_HWSTBY;
                else if (res_n) begin
                    r_d.st     = ST_RUN;
                    r_d.rst_go = 1'b1;
                end
            end
            ST_HWSTBY: begin
                if (hwstby_n) r_d.st = ST_RSTHOLD;
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_RUN, reinit: 1'b0, wake: 1'b0, wake_nmi: 1'b0, rst_go: 1'b0};
        else        r_q <= r_d;
    end

    always_comb begin
        osc_en     = (r_q.st == ST_RUN) || (r_q.st == ST_SETTLE) || (r_q.st == ST_RSTHOLD);
        cpu_clk_en = (r_q.st == ST_RUN) || (r_q.st == ST_RSTHOLD);
        per_clk_en = cpu_clk_en;
        hw_stby    = (r_q.st == ST_HWSTBY);
        per_reinit = r_q.reinit;
        wake_req   = r_q.wake;
        wake_nmi   = r_q.wake & r_q.wake_nmi;
        reset_go   = r_q.rst_go;
    end

endmodule

module stby_ctrl_chk
    import stby_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sleep_req,
    input logic      cfg_stby_en,
    input logic      cfg_lowspd,
    input logic      cfg_wdt_src,
    input logic      irq_mask,
    input logic      res_n,
    input logic      hwstby_n,
    input pm_state_e st_q,
    input logic      nmi_edge,
    input logic      per_reinit,
    input logic      wake_req,
    input logic      osc_en,
    input logic      cpu_clk_en,
    input logic      hw_stby
);

    logic ok;
    assign ok = sleep_req && cfg_stby_en && !cfg_lowspd && !cfg_wdt_src;

    assert_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && hwstby_n && res_n && ok) |=> (st_q == ST_STBY && !cpu_clk_en));

    assert_stay_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && hwstby_n && res_n && !ok) |=> (st_q == ST_RUN && cpu_clk_en));

    assert_reinit_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        per_reinit |-> (st_q == ST_STBY && $past(st_q) == ST_RUN));

    assert_masked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STBY && hwstby_n && res_n && !nmi_edge && irq_mask) |=> (st_q == ST_STBY));

    assert_wake_after_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (cpu_clk_en && $past(st_q) == ST_SETTLE));

    assert_reset_clocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STBY && hwstby_n && !res_n) |=> (osc_en && cpu_clk_en));

    assert_hw_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hwstby_n |=> (hw_stby && !osc_en));

endmodule

bind stby_ctrl stby_ctrl_chk u_stby_ctrl_chk (.*);

// File: tb/test_stby_ctrl.sv
module test_stby_ctrl;

    localparam int BASE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0, cfg_stby_en = 1'b0, cfg_lowspd = 1'b0, cfg_wdt_src = 1'b0;
    logic [2:0] cfg_settle_sel = 3'd0;
    logic       cfg_nmi_rise = 1'b1;
    logic [7:0] irq_req = '0, irq_en = '0;
    logic       irq_mask = 1'b0, nmi_pin = 1'b0, res_n = 1'b1, hwstby_n = 1'b1;
    logic       osc_en, cpu_clk_en, per_clk_en, per_reinit, wake_req, wake_nmi, reset_go, hw_stby;

    int n_cmp = 0;
    int n_mis = 0;
    int cyc = 0;
    bit fin = 1'b0;

    always #2.5 clk = ~clk;

    stby_ctrl #(.BASE_LOG2(BASE)) i_stby_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cfg_stby_en(cfg_stby_en),
        .cfg_lowspd(cfg_lowspd), .cfg_wdt_src(cfg_wdt_src), .cfg_settle_sel(cfg_settle_sel),
        .cfg_nmi_rise(cfg_nmi_rise), .irq_req(irq_req), .irq_en(irq_en), .irq_mask(irq_mask),
        .nmi_pin(nmi_pin), .res_n(res_n), .hwstby_n(hwstby_n), .osc_en(osc_en),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .per_reinit(per_reinit),
        .wake_req(wake_req), .wake_nmi(wake_nmi), .reset_go(reset_go), .hw_stby(hw_stby)
    );

    function automatic bit exp_irq_wake(logic [7:0] req, logic [7:0] en, logic msk);
        return ((req & en & 8'b1100_0111) != 8'h00) && !msk;
    endfunction

    function automatic int settle_len(logic [2:0] sel);
        return 1 << (BASE + int'(sel));
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        if (!fin) begin
            fin = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !fin) begin
            n_cmp++;
            n_mis++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic enter_standby(logic [2:0] sel);
        cfg_stby_en = 1'b1; cfg_lowspd = 1'b0; cfg_wdt_src = 1'b0;
        cfg_settle_sel = sel;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R2", "cpu_clk_en in standby", 32'(cpu_clk_en), 0);
        chk("R2", "per_clk_en in standby", 32'(per_clk_en), 0);
        chk("R2", "osc_en in standby", 32'(osc_en), 0);
        chk("R3", "per_reinit on entry", 32'(per_reinit), 1);
        step();
        chk("R3", "per_reinit after entry", 32'(per_reinit), 0);
    endtask

    task automatic wait_settle(logic [2:0] sel, logic src_nmi);
        int len = settle_len(sel);
        chk("R6", "osc_en at settle start", 32'(osc_en), 1);
        chk("R6", "cpu_clk_en at settle start", 32'(cpu_clk_en), 0);
        repeat (len - 1) step();
        chk("R6", "cpu_clk_en before settle end", 32'(cpu_clk_en), 0);
        step();
        chk("R6", "cpu_clk_en after settle", 32'(cpu_clk_en), 1);
        chk("R6", "wake_req after settle", 32'(wake_req), 1);
        chk("R6", "wake_nmi source", 32'(wake_nmi), 32'(src_nmi));
        step();
        chk("R6", "wake_req one cycle", 32'(wake_req), 0);
    endtask

    initial begin
        void'($urandom(32'd7319));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R2", "reset osc_en", 32'(osc_en), 1);
        chk("R2", "reset cpu_clk_en", 32'(cpu_clk_en), 1);
        chk("R8", "reset hw_stby", 32'(hw_stby), 0);
        chk("R6", "reset wake_req", 32'(wake_req), 0);

        // R1 / R11: all gating combinations except the allowed one keep run state
        for (int c = 0; c < 8; c++) begin
            if (c == 4) continue;
            {cfg_stby_en, cfg_lowspd, cfg_wdt_src} = 3'(c);
            sleep_req = 1'b1;
            step();
            sleep_req = 1'b0;
            chk("R11", $sformatf("stays run cfg=%0d", c), 32'(cpu_clk_en), 1);
            chk("R1", $sformatf("no reinit cfg=%0d", c), 32'(per_reinit), 0);
        end

        // R4: non-wake lines 3,4,5 ignored
        enter_standby(3'd0);
        irq_en = 8'hFF; irq_req = 8'b0011_1000;
        repeat (4) step();
        chk("R4", "lines 3-5 no wake", 32'(osc_en), 0);
        // R5: disabled line and masked line
        irq_req = 8'b0000_0010; irq_en = 8'b1111_1101;
        repeat (3) step();
        chk("R5", "disabled line no wake", 32'(osc_en), 0);
        irq_en = 8'hFF; irq_mask = 1'b1;
        repeat (3) step();
        chk("R5", "masked no wake", 32'(osc_en), 0);
        irq_mask = 1'b0; irq_req = 8'b0100_0000;
        step();
        wait_settle(3'd0, 1'b0);
        irq_req = '0;

        // R9: falling-edge select; rising edge must not wake
        cfg_nmi_rise = 1'b0;
        enter_standby(3'd1);
        nmi_pin = 1'b1;
        repeat (3) step();
        chk("R9", "wrong edge no wake", 32'(osc_en), 0);
        nmi_pin = 1'b0;
        step();
        wait_settle(3'd1, 1'b1);
        cfg_nmi_rise = 1'b1;

        // R10: NMI and IRQ together -> NMI reported
        enter_standby(3'd0);
        nmi_pin = 1'b1; irq_req = 8'h01; irq_en = 8'h01;
        step();
        wait_settle(3'd0, 1'b1);
        nmi_pin = 1'b0; irq_req = '0;
        step();

        // R7 + R10: reset together with NMI edge -> reset hold wins
        enter_standby(3'd2);
        res_n = 1'b0; nmi_pin = 1'b1;
        step();
        chk("R7", "osc on with reset low", 32'(osc_en), 1);
        chk("R7", "clocks on with reset low", 32'(cpu_clk_en), 1);
        repeat (40) step();
        chk("R10", "reset beats nmi: no wake", 32'(wake_req), 0);
        chk("R7", "no reset_go while held", 32'(reset_go), 0);
        res_n = 1'b1;
        step();
        chk("R7", "reset_go pulse", 32'(reset_go), 1);
        step();
        chk("R7", "reset_go one cycle", 32'(reset_go), 0);
        nmi_pin = 1'b0;
        step();

        // R8 + R10: hw standby beats reset and NMI
        enter_standby(3'd0);
        hwstby_n = 1'b0; res_n = 1'b0; nmi_pin = 1'b1;
        step();
        chk("R8", "hw_stby entered", 32'(hw_stby), 1);
        chk("R10", "hw beats reset: osc off", 32'(osc_en), 0);
        hwstby_n = 1'b1; res_n = 1'b1;
        step();
        chk("R8", "hw release to reset hold", 32'(hw_stby), 0);
        chk("R8", "reset hold clocks", 32'(cpu_clk_en), 1);
        step();
        chk("R8", "reset_go after hw release", 32'(reset_go), 1);
        nmi_pin = 1'b0;
        step();

        // Random IRQ mixes with random settle lengths
        for (int it = 0; it < 24; it++) begin
            logic [2:0] sel = 3'($urandom_range(0, 7));
            logic [7:0] rq = 8'($urandom);
            logic [7:0] en = 8'($urandom);
            logic       mk = ($urandom_range(0, 3) == 0);
            bit         w  = exp_irq_wake(rq, en, mk);
            enter_standby(sel);
            irq_req = rq; irq_en = en; irq_mask = mk;
            step();
            chk(w ? "R4" : "R5", $sformatf("rand irq rq=%0h en=%0h mk=%0d", rq, en, mk),
                32'(osc_en), 32'(w));
            if (w) begin
                wait_settle(sel, 1'b0);
                irq_req = '0; irq_mask = 1'b0;
            end else begin
                irq_req = '0; irq_mask = 1'b0;
                nmi_pin = 1'b1;
                step();
                wait_settle(sel, 1'b1);
                nmi_pin = 1'b0;
            end
            step();
        end

        summary();
    end

endmodule